// File: doc/BRIEF.md
# Inactivity Timer Reload Controller

This block counts down a period of system inactivity and restarts that count whenever one of a set of selected activity sources shows that the system is busy. A 32-bit configuration register chooses which sources may restart the timer. The sources are sixteen interrupt request lines, a non-maskable interrupt input, a processor init input, a bus-master activity event and an external SMI status flag. Interrupt lines count as activity on any change of level. The non-maskable interrupt and init inputs count on their rising edge. A bus-master event counts in every cycle it is high. The external SMI status works differently: while it is set and selected, it pins the timer at its start value.

The start value sits in a separate register that is written through its own strobe. Writing the start value does not restart the count. The counter steps down by one on each `tick` cycle. When it reaches zero it raises a sticky `expired` flag and stops. The next restart clears the flag. The asynchronous interrupt, NMI and init inputs pass through a synchronizer before their edges are detected. The controller interrupt slot (slot 2 by default) does not watch its own request line. It watches the combined output of the interrupt controller, which is either the legacy controller or the APIC depending on a mode input.

Top module: `idle_reload_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `count` is 0 and `expired` is 0. With the configuration still at 0, no source restarts the timer.
- R2: Configuration bits 31:20 always read as 0, and writing to them has no effect. Bits 19:0 read back the value written.
- R3: Setting configuration bit n (0 to 15, n not 2) lets `irq_in[n]` restart the timer on each change of level, low-to-high or high-to-low. A steady level causes no restart. With the default two-stage synchronizer, `count` shows the start value after the third rising clock edge following the change.
- R4: Configuration bit 2 watches `apic_int` when `apic_mode` is 1 and `pic_int` when it is 0. Any change of the selected signal restarts the timer. `irq_in[2]` has no effect.
- R5: Bit 16 lets a rising edge of `nmi_in` restart the timer, and bit 17 does the same for `init_in`, with the same latency as R3. A falling edge causes no restart.
- R6: While bit 18 is set and `extsmi_sts` is 1, `count` is loaded with the start value on every clock edge, so it does not decrement even when `tick` is high. After the status clears, the count decrements again.
- R7: While bit 19 is set, each cycle with `bm_event` high restarts the timer at the next clock edge.
- R8: On each edge where `tick` is 1 and no restart occurs, a nonzero `count` drops by 1. The step from 1 to 0 sets `expired`. At 0, the count stays at 0 and `expired` stays set until the next restart.
- R9: A restart loads the start value last written through `reload_we`/`reload_val` and clears `expired`. A restart takes priority over a tick in the same cycle.
- R10: A source whose configuration bit is 0 causes no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| reload_we | input | 1 | Start-value write strobe |
| reload_val | input | CNT_W | Start value to store |
| irq_in | input | 16 | Interrupt request lines (asynchronous) |
| pic_int | input | 1 | Legacy interrupt controller output |
| apic_int | input | 1 | APIC interrupt output |
| apic_mode | input | 1 | 1 selects `apic_int` for slot 2 |
| nmi_in | input | 1 | Non-maskable interrupt (asynchronous) |
| init_in | input | 1 | Processor init (asynchronous) |
| bm_event | input | 1 | Bus-master activity event (synchronous) |
| extsmi_sts | input | 1 | External SMI status flag (synchronous) |
| tick | input | 1 | Decrement enable |
| count | output | CNT_W | Current timer value |
| expired | output | 1 | Sticky expiry flag |

## Verification
The assertions check rules that hold on every cycle. The reserved configuration bits always read zero. A restart always loads the stored start value. A tick without a restart always steps a nonzero count down by exactly one. The count never wraps below zero. `expired` never coexists with a nonzero count. Only the bench scenarios can show which inputs produce a restart and when. These cover the per-line enables, changes in both directions, the slot-2 controller selection, rising-only edges on NMI and init, and the hold while the SMI status is set. They also show the exact synchronizer latency, so they are the only evidence that a disabled or steady source leaves the count alone.

// File: rtl/irt_pkg.sv
package irt_pkg;
   localparam int CFG_W      = 32;
   localparam int IRQ_LINES  = 16;
   localparam int BIT_NMI    = 16;
   localparam int BIT_INIT   = 17;
   localparam int BIT_EXTSMI = 18;
   localparam int BIT_BM     = 19;
   localparam int LIVE_BITS  = 20;
   localparam logic [CFG_W-1:0] CFG_WRITABLE = (CFG_W'(1) << LIVE_BITS) - CFG_W'(1);

   typedef struct packed {
      logic                 bm;
      logic                 extsmi;
      logic                 init;
      logic                 nmi;
      logic [IRQ_LINES-1:0] irq;
   } reload_en_t;

   function automatic reload_en_t decode_cfg(input logic [CFG_W-1:0] r);
      reload_en_t e;
      e.irq    = r[IRQ_LINES-1:0];
      e.nmi    = r[BIT_NMI];
      e.init   = r[BIT_INIT];
      e.extsmi = r[BIT_EXTSMI];
      e.bm     = r[BIT_BM];
      return e;
   endfunction
endpackage

// File: rtl/irt_cfg_reg.sv
module irt_cfg_reg
   import irt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output reload_en_t       en
);
   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (we)
         cfg_q <= wdata & CFG_WRITABLE;
   end

   assign rdata = cfg_q;
   assign en    = decode_cfg(cfg_q);
endmodule

// File: rtl/irt_sync.sv
module irt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irt_event_detect.sv
module irt_event_detect
   import irt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_SLOT   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  reload_en_t           en,
   input  logic [IRQ_LINES-1:0] irq_in,
   input  logic                 pic_int,
   input  logic                 apic_int,
   input  logic                 apic_mode,
   input  logic                 nmi_in,
   input  logic                 init_in,
   input  logic                 bm_event,
   input  logic                 extsmi_sts,
   output logic                 reload_req
);
   localparam int NSRC = IRQ_LINES + 2;
   localparam int S_NMI  = IRQ_LINES;
   localparam int S_INIT = IRQ_LINES + 1;

   generate
      if (CTRL_SLOT < 0 || CTRL_SLOT >= IRQ_LINES) begin : g_bad_slot
         $error("irt_event_detect: CTRL_SLOT out of range");
      end
   endgenerate

   logic                 ctrl_int;
   logic [NSRC-1:0]      raw;
   logic [NSRC-1:0]      synced;
   logic [NSRC-1:0]      prev_q;
   logic [IRQ_LINES-1:0] irq_hit;
   logic                 nmi_hit, init_hit, bm_hit, smi_hold;

   assign ctrl_int = apic_mode ? apic_int : pic_int;

   always_comb begin
      raw                   = {init_in, nmi_in, irq_in};
      raw[CTRL_SLOT]        = ctrl_int;
   end

   irt_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (synced)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   genvar g;
   generate
      for (g = 0; g < IRQ_LINES; g++) begin : g_irq
         assign irq_hit[g] = en.irq[g] & (synced[g] ^ prev_q[g]);
      end
   endgenerate

   assign nmi_hit  = en.nmi  & synced[S_NMI]  & ~prev_q[S_NMI];
   assign init_hit = en.init & synced[S_INIT] & ~prev_q[S_INIT];
   assign bm_hit   = en.bm & bm_event;
   assign smi_hold = en.extsmi & extsmi_sts;

   assign reload_req = (|irq_hit) | nmi_hit | init_hit | bm_hit | smi_hold;
endmodule

// File: rtl/irt_countdown.sv
module irt_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             reload_req,
   output logic [CNT_W-1:0] count,
   output logic             expired,
   output logic [CNT_W-1:0] start_q
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("irt_countdown: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             exp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         start_q <= '0;
      else if (reload_we) start_q <= reload_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (reload_req) begin
         cnt_q <= start_q;
         exp_q <= 1'b0;
      end else if (tick && cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) exp_q <= 1'b1;
      end
   end

   assign count   = cnt_q;
   assign expired = exp_q;
endmodule

// File: rtl/idle_reload_timer.sv
module idle_reload_timer
   import irt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_SLOT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [15:0]      irq_in,
   input  logic             pic_int,
   input  logic             apic_int,
   input  logic             apic_mode,
   input  logic             nmi_in,
   input  logic             init_in,
   input  logic             bm_event,
   input  logic             extsmi_sts,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expired
);
   reload_en_t       en;
   logic             reload_req;
   logic [CNT_W-1:0] start_q;

   irt_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .en    (en)
   );

   irt_event_detect #(.SYNC_STAGES(SYNC_STAGES), .CTRL_SLOT(CTRL_SLOT)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .irq_in     (irq_in),
      .pic_int    (pic_int),
      .apic_int   (apic_int),
      .apic_mode  (apic_mode),
      .nmi_in     (nmi_in),
      .init_in    (init_in),
      .bm_event   (bm_event),
      .extsmi_sts (extsmi_sts),
      .reload_req (reload_req)
   );

   irt_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_we  (reload_we),
      .reload_val (reload_val),
      .tick       (tick),
      .reload_req (reload_req),
      .count      (count),
      .expired    (expired),
      .start_q    (start_q)
   );
endmodule

// File: rtl/irt_checker.sv
module irt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      cfg_rdata,
   input logic             reload_req,
   input logic             tick,
   input logic [CNT_W-1:0] start_q,
   input logic [CNT_W-1:0] count,
   input logic             expired,
   input logic             extsmi_sts
);
   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[31:20] == 12'h000);

   p_reload_loads_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> count == $past(start_q));

   p_tick_steps_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_req && tick && count != '0) |=> count == $past(count) - CNT_W'(1));

   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_req && count == '0) |=> count == '0);

   p_expired_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expired |-> count == '0);

   p_reload_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> !expired);

   p_hold_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_req && tick && count != '0) |-> !(extsmi_sts && cfg_rdata[18]));
endmodule

bind idle_reload_timer irt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rdata  (cfg_rdata),
   .reload_req (reload_req),
   .tick       (tick),
   .start_q    (start_q),
   .count      (count),
   .expired    (expired),
   .extsmi_sts (extsmi_sts)
);

// File: tb/idle_reload_timer_tb_top.sv
module idle_reload_timer_tb_top;
   localparam int CW = 16;
   localparam int LAT = 3;
   localparam logic [CW-1:0] RV = 16'd100;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          cfg_we = 0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          reload_we = 0;
   logic [CW-1:0] reload_val = '0;
   logic [15:0]   irq_in = '0;
   logic          pic_int = 0, apic_int = 0, apic_mode = 0;
   logic          nmi_in = 0, init_in = 0, bm_event = 0, extsmi_sts = 0, tick = 0;
   logic [CW-1:0] count;
   logic          expired;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   idle_reload_timer #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .reload_we(reload_we), .reload_val(reload_val),
      .irq_in(irq_in), .pic_int(pic_int), .apic_int(apic_int),
      .apic_mode(apic_mode), .nmi_in(nmi_in), .init_in(init_in),
      .bm_event(bm_event), .extsmi_sts(extsmi_sts), .tick(tick),
      .count(count), .expired(expired)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [31:0] v);
      cfg_we = 1; cfg_wdata = v; cycles(1); cfg_we = 0;
   endtask

   // restart through the bus-master source, then tick 5 times: count = RV-5
   task automatic prime(input logic [31:0] mask);
      write_cfg(mask | 32'h0008_0000);
      bm_event = 1; cycles(1); bm_event = 0;
      tick = 1; cycles(5); tick = 0;
      write_cfg(mask);
      cycles(LAT + 1);
   endtask

   task automatic t_reset;
      check("R1 cfg", cfg_rdata, 0);
      check("R1 count", count, 0);
      check("R1 expired", expired, 0);
      reload_we = 1; reload_val = RV; cycles(1); reload_we = 0;
      irq_in = 16'hFFFF; nmi_in = 1; init_in = 1; bm_event = 1; extsmi_sts = 1;
      cycles(LAT + 2);
      check("R1 no reload when disabled", count, 0);
      irq_in = '0; nmi_in = 0; init_in = 0; bm_event = 0; extsmi_sts = 0;
      cycles(LAT + 2);
   endtask

   task automatic t_cfg;
      write_cfg(32'hFFFF_FFFF);
      check("R2 reserved read zero", cfg_rdata, 32'h000F_FFFF);
      write_cfg(32'hABC5_A5A5);
      check("R2 readback", cfg_rdata, 32'h0005_A5A5);
      write_cfg(0);
   endtask

   task automatic t_irq;
      prime(32'h0000_0020);
      irq_in[5] = 1; cycles(LAT - 1);
      check("R3 not before latency", count, RV - 5);
      cycles(1);
      check("R3 rise reload", count, RV);
      tick = 1; cycles(4); tick = 0;
      cycles(LAT);
      check("R3 steady level no reload", count, RV - 4);
      irq_in[5] = 0; cycles(LAT);
      check("R3 fall reload", count, RV);
      prime(32'h0000_0020);
      irq_in[6] = 1; cycles(LAT + 1);
      check("R10 disabled irq", count, RV - 5);
      irq_in[6] = 0; cycles(LAT + 1);
   endtask

   task automatic t_slot2;
      prime(32'h0000_0004);
      irq_in[2] = 1; cycles(LAT + 1);
      check("R4 irq2 ignored", count, RV - 5);
      apic_int = 1; cycles(LAT + 1);
      check("R4 apic ignored in pic mode", count, RV - 5);
      pic_int = 1; cycles(LAT);
      check("R4 pic toggle reload", count, RV);
      prime(32'h0000_0004);
      apic_mode = 1; pic_int = 0; apic_int = 1; cycles(LAT + 1);
      check("R4 apic mode no change", count, RV - 5);
      apic_int = 0; cycles(LAT);
      check("R4 apic toggle reload", count, RV);
      irq_in[2] = 0; apic_mode = 0; cycles(LAT + 1);
   endtask

   task automatic t_nmi_init;
      prime(32'h0003_0000);
      nmi_in = 1; cycles(LAT);
      check("R5 nmi rise", count, RV);
      tick = 1; cycles(3); tick = 0;
      nmi_in = 0; cycles(LAT + 1);
      check("R5 nmi fall no reload", count, RV - 3);
      init_in = 1; cycles(LAT);
      check("R5 init rise", count, RV);
      init_in = 0; cycles(LAT + 1);
      write_cfg(0);
   endtask

   task automatic t_smi;
      prime(32'h0004_0000);
      extsmi_sts = 1; tick = 1; cycles(1);
      check("R6 hold loads", count, RV);
      cycles(6);
      check("R6 held under ticks", count, RV);
      extsmi_sts = 0; cycles(3);
      check("R6 released decrements", count, RV - 3);
      tick = 0;
      write_cfg(0);
      extsmi_sts = 1; tick = 1; cycles(2);
      check("R10 smi disabled", count, RV - 5);
      extsmi_sts = 0; tick = 0;
   endtask

   task automatic t_bm_expire;
      reload_we = 1; reload_val = 3; cycles(1); reload_we = 0;
      write_cfg(32'h0008_0000);
      bm_event = 1; cycles(1); bm_event = 0;
      check("R7 bm reload next edge", count, 3);
      tick = 1; cycles(2);
      check("R8 decrement", count, 1);
      check("R8 not yet expired", expired, 0);
      cycles(1);
      check("R8 expiry", expired, 1);
      cycles(4);
      check("R8 stops at zero", count, 0);
      check("R8 sticky", expired, 1);
      bm_event = 1; cycles(1); bm_event = 0;
      check("R9 reload priority over tick", count, 3);
      check("R9 reload clears expiry", expired, 0);
      tick = 0;
      reload_we = 1; reload_val = 16'd7; cycles(1); reload_we = 0;
      check("R9 write does not reload", count, 3);
      bm_event = 1; cycles(1); bm_event = 0;
      check("R9 new start value", count, 7);
      write_cfg(0);
   endtask

   initial begin
      cycles(3);
      rst_n = 1;
      cycles(1);
      t_reset;
      t_cfg;
      t_irq;
      t_slot2;
      t_nmi_init;
      t_smi;
      t_bm_expire;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #200000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule